// File: doc/BRIEF.md
# SPI Slave Shift Channel with Select Gating

This block is the shift engine of an 8-bit SPI slave. An external master supplies the serial clock, the serial data in and an active-low select. The block shifts a byte out on its serial data output and a byte in from the serial data input, most significant bit first. The select line gates every shift and sample. While the slave is deselected, its output enable is low so that the pad can float. A clock-polarity control and a data-phase control pick which serial clock edge drives data and which edge samples it. With the alternate phase, the first bit appears on the data line as soon as a byte is written, even while the slave is deselected.

All three serial inputs pass through two-flop synchronizers and are handled in the system clock domain. The serial clock must therefore run well below the system clock: each serial clock level must last several system clock cycles. Transmit bytes enter through a valid/ready port. Ready is low while the one-byte holding buffer is full, and a write is taken only in a cycle where valid and ready are both high. The buffer empties when its byte moves into the shift register, which happens whenever no frame is in progress. Received bytes leave through a one-cycle valid pulse with no ready. The byte stays on the data output until the next frame completes, so a consumer that cannot take it at once must copy it in the pulse cycle. A select-enable control lets the select pin be ignored for single-slave wiring.

Top module: `spi_sel_slave`

## Requirements
- R1: A transmit write is accepted when `tx_valid_i` and `tx_ready_o` are both high at a clock edge. After that edge `tx_full_o` is 1 and `tx_ready_o` is 0.
- R2: A full buffer moves into the shift register at the first clock edge at which `busy_o` is 0. `tx_full_o` reads 0 after that edge and `tx_ready_o` reads 1.
- R3: Each frame is 8 bits. Bits leave on `miso_o` and are taken from `mosi_i` in the order bit 7 first, bit 0 last. The received byte appears on `rx_data_o`.
- R4: With `phase_i`=0, data is sampled on the rising edge of the normalized clock and the next bit is driven on its falling edge. Bit 7 is presented when the slave becomes selected.
- R5: With `phase_i`=1, the normalized rising edge drives a bit (the first rising edge keeps bit 7) and the falling edge samples.
- R6: The normalized clock is `sclk_i` XOR `cpol_i`, so `cpol_i`=1 swaps every edge role. The idle level of `sclk_i` is expected to equal `cpol_i`.
- R7: With `phase_i`=1, writing a byte while idle puts its bit 7 on `miso_o`, even while deselected. With `phase_i`=0, `miso_o` does not change while deselected.
- R8: While deselected, serial clock edges neither shift nor sample. A frame interrupted by deselection resumes where it stopped, and a deselected burst leaves the next frame intact.
- R9: `miso_oe_o` is 1 exactly while the slave counts as selected, and 0 while `ssn_i` is high with `sel_en_i`=1.
- R10: With `sel_en_i`=0, `ssn_i` is ignored and the slave counts as always selected.
- R11: `busy_o` rises at the first active edge of a frame and falls at the eighth sample. For `phase_i`=0 the first active edge is the first sample edge; for `phase_i`=1 it is the first drive edge.
- R12: At the eighth sample, `rx_valid_o` pulses high for exactly one cycle with the byte on `rx_data_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data in |
| ssn_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data out value |
| miso_oe_o | output | 1 | Output enable for the serial data out pad |
| sel_en_i | input | 1 | 1: honour `ssn_i`; 0: always selected |
| phase_i | input | 1 | Data phase choice |
| cpol_i | input | 1 | Clock polarity choice |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Holding buffer can take a byte |
| tx_data_i | input | 8 | Transmit byte |
| tx_full_o | output | 1 | Holding buffer full |
| busy_o | output | 1 | Frame in progress |
| rx_valid_o | output | 1 | One-cycle received-byte strobe |
| rx_data_o | output | 8 | Last received byte |

## Verification
The assertions watch, on every cycle, the properties that a single cycle or the following one can show. These are: the valid pulse is one cycle wide, `busy_o` is low at each pulse, bit count and receive register stay frozen while deselected, the buffer fills on an accepted write and empties on the next idle edge, and the output enable follows the select rules. Only the bench scenarios can show the properties that span a whole frame. These are: correct bit order on both lines in all four polarity/phase settings, early presentation of bit 7 in the alternate phase, a deselected clock burst that leaves the next frame undisturbed, and operation with the select pin ignored.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  localparam int unsigned FRAME_BITS_DEF = 8;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;
endpackage

// File: rtl/spi_sel_sync.sv
module spi_sel_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned DEPTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [DEPTH-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {DEPTH{RST_VAL[g]}};
      else        chain <= {chain[DEPTH-2:0], d_i[g]};
    end
    assign q_o[g] = chain[DEPTH-1];
  end
endmodule

// File: rtl/spi_sel_edge.sv
module spi_sel_edge
  import spi_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  output sclk_edge_t edge_o
);
  logic prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end
  assign edge_o.rise = lvl_i & ~prev_q;
  assign edge_o.fall = ~lvl_i & prev_q;
endmodule

// File: rtl/spi_sel_shift.sv
module spi_sel_shift
  import spi_sel_pkg::*;
#(
  parameter int unsigned FRAME_BITS = FRAME_BITS_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_i,
  input  logic                  sel_rise_i,
  input  sclk_edge_t            edge_i,
  input  logic                  phase_i,
  input  logic                  mosi_i,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] load_data_i,
  output logic                  dout_o,
  output logic                  busy_o,
  output logic                  rx_valid_o,
  output logic [FRAME_BITS-1:0] rx_data_o
);
  localparam int unsigned CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] tx_sr, rx_sr;
  logic [CW-1:0]         bit_cnt;
  logic                  drive_e, samp_e;

  assign drive_e = sel_i & (phase_i ? edge_i.rise : edge_i.fall);
  assign samp_e  = sel_i & (phase_i ? edge_i.fall : edge_i.rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr      <= '0;
      rx_sr      <= '0;
      bit_cnt    <= '0;
      dout_o     <= 1'b0;
      busy_o     <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (sel_rise_i && !phase_i && !busy_o) dout_o <= tx_sr[FRAME_BITS-1];
      if (drive_e) begin
        if (phase_i && !busy_o) begin
          busy_o <= 1'b1;
          dout_o <= tx_sr[FRAME_BITS-1];
        end else if (busy_o) begin
          dout_o <= tx_sr[FRAME_BITS-2];
          tx_sr  <= {tx_sr[FRAME_BITS-2:0], 1'b0};
        end
      end
      if (samp_e && (busy_o || !phase_i)) begin
        rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_i};
        if (bit_cnt == LAST) begin
          bit_cnt    <= '0;
          busy_o     <= 1'b0;
          rx_valid_o <= 1'b1;
          rx_data_o  <= {rx_sr[FRAME_BITS-2:0], mosi_i};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          busy_o  <= 1'b1;
        end
      end
      if (load_i) begin
        tx_sr <= load_data_i;
        if (phase_i || sel_i) dout_o <= load_data_i[FRAME_BITS-1];
      end
    end
  end

  a_r12_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  a_r11_idle_at_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> !busy_o);
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> ($stable(bit_cnt) && $stable(rx_sr)));
endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spi_sel_pkg::*;
#(
  parameter int unsigned FRAME_BITS = FRAME_BITS_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_i,
  input  logic                  mosi_i,
  input  logic                  ssn_i,
  output logic                  miso_o,
  output logic                  miso_oe_o,
  input  logic                  sel_en_i,
  input  logic                  phase_i,
  input  logic                  cpol_i,
  input  logic                  tx_valid_i,
  output logic                  tx_ready_o,
  input  logic [FRAME_BITS-1:0] tx_data_i,
  output logic                  tx_full_o,
  output logic                  busy_o,
  output logic                  rx_valid_o,
  output logic [FRAME_BITS-1:0] rx_data_o
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0]      sync_q;
  logic                  sclk_s, ssn_s, mosi_s;
  logic                  sel, sel_q, load;
  logic [FRAME_BITS-1:0] hold_q;
  sclk_edge_t            sedge;

  spi_sel_sync #(.WIDTH(NSYNC), .DEPTH(SYNC_DEPTH), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({mosi_i, ssn_i, sclk_i}), .q_o(sync_q));
  assign {mosi_s, ssn_s, sclk_s} = sync_q;

  spi_sel_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sclk_s ^ cpol_i), .edge_o(sedge));

  assign sel = sel_en_i ? ~ssn_s : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel;
  end

  assign tx_ready_o = ~tx_full_o;
  assign load       = tx_full_o & ~busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full_o <= 1'b0;
      hold_q    <= '0;
    end else if (tx_valid_i && tx_ready_o) begin
      tx_full_o <= 1'b1;
      hold_q    <= tx_data_i;
    end else if (load) begin
      tx_full_o <= 1'b0;
    end
  end

  spi_sel_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sel_rise_i(sel & ~sel_q),
    .edge_i(sedge), .phase_i(phase_i), .mosi_i(mosi_s), .load_i(load),
    .load_data_i(hold_q), .dout_o(miso_o), .busy_o(busy_o),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o));

  assign miso_oe_o = sel;

  a_r1_full_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> (tx_full_o && !tx_ready_o));
  a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full_o && !busy_o) |=> !tx_full_o);
  a_r10_forced_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_en_i |-> miso_oe_o);
  a_r9_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en_i && ssn_s) |-> !miso_oe_o);
endmodule

// File: tb/spi_sel_slave_tb.sv
module spi_sel_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, ssn = 1'b1;
  logic sel_en = 1'b1, phase = 1'b0, cpol = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic miso, miso_oe, tx_ready, tx_full, busy, rx_valid;
  logic [7:0] rx_data;

  int total = 0, bad = 0, rx_seen = 0;
  logic [7:0] exp_q[$];
  logic prev_valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sel_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .ssn_i(ssn),
    .miso_o(miso), .miso_oe_o(miso_oe), .sel_en_i(sel_en), .phase_i(phase),
    .cpol_i(cpol), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_data_i(tx_data), .tx_full_o(tx_full), .busy_o(busy),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops expected received bytes
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_seen++;
        check(!prev_valid, "R12 pulse width", 1, 0);
        if (exp_q.size() == 0) check(1'b0, "R3 unexpected byte", rx_data, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          check(rx_data == e, "R3 received byte", rx_data, e);
          check(!busy, "R11 busy low at byte", busy, 0);
        end
      end
      prev_valid <= rx_valid;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [7:0] d);
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // master frame; returns the byte seen on miso
  task automatic frame(input logic [7:0] m, input bit use_ssn, output logic [7:0] got);
    exp_q.push_back(m);
    if (!phase) mosi = m[7];
    if (use_ssn) ssn = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      idle(HALF);
      if (!phase) begin
        got[i] = miso;
        sclk = ~cpol;
        if (i == 4) begin idle(2); check(busy, "R11 busy mid frame", busy, 1); idle(HALF-2); end
        else idle(HALF);
        sclk = cpol;
        if (i > 0) mosi = m[i-1];
      end else begin
        sclk = ~cpol; mosi = m[i];
        idle(HALF);
        got[i] = miso;
        if (i == 4) check(busy, "R11 busy mid frame", busy, 1);
        sclk = cpol;
      end
    end
    idle(HALF);
    if (use_ssn) ssn = 1'b1;
    idle(4);
  endtask

  task automatic xfer(input logic [7:0] s, input logic [7:0] m, input string tag);
    logic [7:0] got;
    write_tx(s);
    idle(2);
    frame(m, sel_en, got);
    check(got == s, tag, got, s);
    check(!busy, "R11 busy low after frame", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    logic [7:0] got;
    logic m0;
    int seen0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    check(tx_ready && !tx_full, "R1 reset ready", {tx_ready, tx_full}, 2);
    check(!busy && !rx_valid, "R11 reset idle", {busy, rx_valid}, 0);
    check(!miso_oe, "R9 reset hi-z", miso_oe, 0);

    // R1 / R2 buffer handshake
    @(negedge clk); tx_data = 8'h3C; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    check(tx_full && !tx_ready, "R1 full after write", {tx_full, tx_ready}, 2);
    @(negedge clk);
    check(!tx_full && tx_ready, "R2 cleared after load", {tx_full, tx_ready}, 1);
    frame(8'hC3, 1'b1, got);
    check(got == 8'h3C, "R3 R4 phase0 cpol0 miso", got, 8'h3C);

    xfer(8'hA5, 8'h5A, "R4 phase0 cpol0 miso");
    check(!miso_oe, "R9 hi-z when deselected", miso_oe, 0);

    // R6 polarity 1, phase 0
    cpol = 1'b1; sclk = 1'b1; idle(6);
    xfer(8'h81, 8'h7E, "R6 phase0 cpol1 miso");

    // R5 phase 1, both polarities
    phase = 1'b1;
    xfer(8'hD2, 8'h2D, "R5 R6 phase1 cpol1 miso");
    cpol = 1'b0; sclk = 1'b0; idle(6);
    xfer(8'h96, 8'h69, "R5 phase1 cpol0 miso");

    // R7 early bit 7 in phase 1 while deselected
    m0 = miso;
    write_tx({~m0, 7'h15});
    idle(3);
    check(miso == ~m0, "R7 phase1 early bit7", miso, ~m0);
    check(!miso_oe, "R9 hi-z while early bit7", miso_oe, 0);
    frame(8'h0F, 1'b1, got);
    check(got == {~m0, 7'h15}, "R7 frame after early bit7", got, {~m0, 7'h15});

    // R7 phase 0: miso unchanged while deselected
    phase = 1'b0; idle(4);
    m0 = miso;
    write_tx({~m0, 7'h2A});
    idle(3);
    check(miso == m0, "R7 phase0 miso held deselected", miso, m0);
    frame(8'hF0, 1'b1, got);
    check(got == {~m0, 7'h2A}, "R4 phase0 bit7 on select", got, {~m0, 7'h2A});

    // R8 gating: burst of clocks while deselected
    write_tx(8'hE7);
    idle(3);
    seen0 = rx_seen;
    m0 = miso;
    for (int k = 0; k < 8; k++) begin
      sclk = 1'b1; mosi = k[0]; idle(HALF);
      sclk = 1'b0; idle(HALF);
    end
    idle(4);
    check(rx_seen == seen0, "R8 no byte while deselected", rx_seen, seen0);
    check(!busy, "R8 busy stays low", busy, 0);
    check(miso == m0, "R8 miso not shifted", miso, m0);
    frame(8'h18, 1'b1, got);
    check(got == 8'hE7, "R8 frame intact after burst", got, 8'hE7);

    // R10 select ignored
    sel_en = 1'b0; ssn = 1'b1; idle(4);
    check(miso_oe, "R10 oe forced on", miso_oe, 1);
    xfer(8'h4B, 8'hB4, "R10 frame with select ignored");
    sel_en = 1'b1; idle(4);
    check(!miso_oe, "R9 hi-z restored", miso_oe, 0);

    idle(20);
    check(exp_q.size() == 0, "R12 all bytes delivered", exp_q.size(), 0);
    summary();
  end
endmodule